// File: doc/BRIEF.md
# Performance counter bank

This block holds a set of 32-bit general event counters and one 64-bit cycle counter behind an indirect register interface. A write port (index plus data, one write per clock) and a combinational read port (index in, data out) reach a global control register, three set/clear register pairs (counter enable, interrupt enable, overflow status), and one value register per counter. Each general counter advances on a one-cycle event pulse supplied from outside; the cycle counter advances on every clock while it is allowed to count.

A small state machine owns the global count enable and the reset-all action. It has three states: `ST_OFF` (counting stopped), `ST_ON` (counting allowed) and `ST_WIPE` (one cycle in which every counter value is forced to zero). A control write with bit 1 or bit 2 set takes any state to `ST_WIPE` and records bit 0 of the same write; any other control write goes to `ST_ON` when bit 0 is 1 and to `ST_OFF` when it is 0; with no control write, `ST_WIPE` leaves for `ST_ON` or `ST_OFF` according to the recorded bit, and `ST_ON` and `ST_OFF` stay put. Software reads the overflow flags, clears the ones it has handled by writing the same mask to the overflow clear index, and preloads counters to half range so an overflow interrupt arrives well before a second wrap.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter value, every enable, interrupt-enable and overflow bit and the global enable are zero, and `irq` is low.
- R2: Index 0x400 is the control register: bit 0 reads back the global enable (1 in `ST_ON`, and in `ST_WIPE` when the pending write had bit 0 set), bits 15:11 read the number of general counters, every other bit reads 0.
- R3: A control write with bit 1 or bit 2 set enters `ST_WIPE`; at the next clock edge all counter values become zero, no counter advances in that cycle, and the state becomes `ST_ON` or `ST_OFF` from bit 0 of that write. Bits 2:1 always read 0.
- R4: The pairs are enable clear/set at 0x403/0x404, interrupt-enable clear/set at 0x405/0x406 and overflow clear/set at 0x407/0x408; a write to a set index ORs the data mask into the state, a write to a clear index removes those bits, and both indices of a pair read the current state.
- R5: In every mask, general counter i uses bit i and the cycle counter uses bit 31; all other bits ignore writes and read 0.
- R6: General counter i adds one on an edge where the state is `ST_ON`, its enable bit is 1 and its event pulse is 1; the cycle counter adds one on each edge in `ST_ON` with enable bit 31 set; otherwise values hold.
- R7: General counter i's value is at 0x421 + 0x10*i (32 bits, data bits 31:0), the cycle counter's at 0x40A (64 bits); both are writable, and a write wins over an increment in the same cycle.
- R8: An increment from all ones to zero sets that counter's overflow bit at the same edge; a hardware overflow in the same cycle as an overflow clear write leaves the bit set.
- R9: `irq` is 1 exactly when some counter has both its overflow bit and its interrupt-enable bit set, and stays 1 until those bits are cleared.
- R10: Every other index, including the per-counter control word at 0x420 + 0x10*i, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 12 | Register index of the write |
| wr_data | input | 64 | Write data (masks use bits 31:0) |
| rd_idx | input | 12 | Register index of the read |
| rd_data | output | 64 | Read data for `rd_idx`, combinational |
| evt | input | NUM_GEN (8) | Increment pulse per general counter |
| irq | output | 1 | Level interrupt for enabled overflows |

## Verification
The bound checker watches on every cycle that a wipe cycle leaves all values at zero, that overflow flags never drop without a clear write, that values stay frozen in `ST_OFF`, that a cycle-counter write lands exactly, that `irq` is low with no overflow and that control, mask and unmapped reads keep their fixed zero bits. Which counter advances under which enable pattern, the wrap into the overflow flag, clear-versus-wrap and write-versus-increment collisions, the enable value restored after a wipe and the level behaviour of the interrupt can only be shown by the bench scenarios, where a behavioural model is compared against the read port and `irq` on each clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int unsigned IDX_W      = 12;
    localparam int unsigned MASK_W     = 32;
    localparam int unsigned CYC_BIT    = 31;
    localparam int unsigned GEN_STRIDE = 16;

    localparam logic [IDX_W-1:0] IX_CTL      = 12'h400;
    localparam logic [IDX_W-1:0] IX_EN_CLR   = 12'h403;
    localparam logic [IDX_W-1:0] IX_EN_SET   = 12'h404;
    localparam logic [IDX_W-1:0] IX_IE_CLR   = 12'h405;
    localparam logic [IDX_W-1:0] IX_IE_SET   = 12'h406;
    localparam logic [IDX_W-1:0] IX_OV_CLR   = 12'h407;
    localparam logic [IDX_W-1:0] IX_OV_SET   = 12'h408;
    localparam logic [IDX_W-1:0] IX_CYC      = 12'h40A;
    localparam logic [IDX_W-1:0] IX_GEN_BASE = 12'h420;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_WIPE = 2'd2
    } pmc_state_e;
endpackage

// File: rtl/pmc_ctl_fsm.sv
module pmc_ctl_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [2:0] ctl_wd,
    output pmc_state_e state,
    output logic       count_on,
    output logic       wipe_now,
    output logic       glob_en_rd
);
    pmc_state_e st_q, st_d;
    logic       resume_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            if (|ctl_wd[2:1])
                st_d = ST_WIPE;
            else if (ctl_wd[0])
                st_d = ST_ON;
            else
                st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_d = ST_OFF;
                ST_ON:   st_d = ST_ON;
                ST_WIPE: st_d = resume_q ? ST_ON : ST_OFF;
                default: st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_OFF;
            resume_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ctl_we)
                resume_q <= ctl_wd[0];
        end
    end

    always_comb begin
        count_on   = 1'b0;
        wipe_now   = 1'b0;
        glob_en_rd = 1'b0;
        unique case (st_q)
            ST_OFF: ;
            ST_ON: begin
                count_on   = 1'b1;
                glob_en_rd = 1'b1;
            end
            ST_WIPE: begin
                wipe_now   = 1'b1;
                glob_en_rd = resume_q;
            end
            default: ;
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/pmc_mask_pair.sv
module pmc_mask_pair #(
    parameter int unsigned W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m, clr_m;

    assign set_m = set_we ? wd : '0;
    assign clr_m = clr_we ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= ((q & ~clr_m) | set_m | hw_set) & VALID;
    end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wipe,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val,
    output logic         wrap
);
    assign wrap = inc & ~ld & ~wipe & (&val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= '0;
        else if (wipe)
            val <= '0;
        else if (ld)
            val <= ld_val;
        else if (inc)
            val <= val + 1'b1;
    end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int unsigned NUM_GEN = 8,
    parameter int unsigned GEN_W   = 32,
    parameter int unsigned CYC_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [CYC_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CYC_W-1:0]   rd_data,
    input  logic [NUM_GEN-1:0] evt,
    output logic               irq
);
    localparam logic [MASK_W-1:0] MASK_VALID =
        (MASK_W'(1) << CYC_BIT) | ((MASK_W'(1) << NUM_GEN) - MASK_W'(1));

    pmc_state_e st;
    logic count_on, wipe_now, glob_en_rd;
    logic [MASK_W-1:0] en_q, ie_q, ovf_q, ovf_hw;
    logic [NUM_GEN-1:0][GEN_W-1:0] gen_val;
    logic [NUM_GEN-1:0] gen_wrap;
    logic [CYC_W-1:0] cyc_val;
    logic cyc_wrap;

    pmc_ctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (wr_en && (wr_idx == IX_CTL)),
        .ctl_wd     (wr_data[2:0]),
        .state      (st),
        .count_on   (count_on),
        .wipe_now   (wipe_now),
        .glob_en_rd (glob_en_rd)
    );

    pmc_mask_pair #(.W(MASK_W), .VALID(MASK_VALID)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && (wr_idx == IX_EN_SET)),
        .clr_we(wr_en && (wr_idx == IX_EN_CLR)),
        .wd(wr_data[MASK_W-1:0]), .hw_set('0), .q(en_q)
    );

    pmc_mask_pair #(.W(MASK_W), .VALID(MASK_VALID)) u_ie (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && (wr_idx == IX_IE_SET)),
        .clr_we(wr_en && (wr_idx == IX_IE_CLR)),
        .wd(wr_data[MASK_W-1:0]), .hw_set('0), .q(ie_q)
    );

    pmc_mask_pair #(.W(MASK_W), .VALID(MASK_VALID)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr_en && (wr_idx == IX_OV_SET)),
        .clr_we(wr_en && (wr_idx == IX_OV_CLR)),
        .wd(wr_data[MASK_W-1:0]), .hw_set(ovf_hw), .q(ovf_q)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam logic [IDX_W-1:0] VAL_IX =
            IX_GEN_BASE + IDX_W'(g * GEN_STRIDE) + IDX_W'(1);
        pmc_counter #(.W(GEN_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (count_on & en_q[g] & evt[g]),
            .wipe   (wipe_now),
            .ld     (wr_en && (wr_idx == VAL_IX)),
            .ld_val (wr_data[GEN_W-1:0]),
            .val    (gen_val[g]),
            .wrap   (gen_wrap[g])
        );
    end

    pmc_counter #(.W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (count_on & en_q[CYC_BIT]),
        .wipe   (wipe_now),
        .ld     (wr_en && (wr_idx == IX_CYC)),
        .ld_val (wr_data),
        .val    (cyc_val),
        .wrap   (cyc_wrap)
    );

    always_comb begin
        ovf_hw               = '0;
        ovf_hw[NUM_GEN-1:0]  = gen_wrap;
        ovf_hw[CYC_BIT]      = cyc_wrap;
    end

    assign irq = |(ovf_q & ie_q);

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IX_CTL: begin
                rd_data[0]     = glob_en_rd;
                rd_data[15:11] = 5'(NUM_GEN);
            end
            IX_EN_CLR, IX_EN_SET: rd_data[MASK_W-1:0] = en_q;
            IX_IE_CLR, IX_IE_SET: rd_data[MASK_W-1:0] = ie_q;
            IX_OV_CLR, IX_OV_SET: rd_data[MASK_W-1:0] = ovf_q;
            IX_CYC:               rd_data = cyc_val;
            default: ;
        endcase
        for (int g = 0; g < NUM_GEN; g++) begin
            if (rd_idx == IX_GEN_BASE + IDX_W'(g * GEN_STRIDE) + IDX_W'(1))
                rd_data[GEN_W-1:0] = gen_val[g];
        end
    end
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
    import pmc_pkg::*;
#(
    parameter int unsigned NUM_GEN = 8,
    parameter int unsigned GEN_W   = 32,
    parameter int unsigned CYC_W   = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic [CYC_W-1:0]              wr_data,
    input logic [IDX_W-1:0]              rd_idx,
    input logic [CYC_W-1:0]              rd_data,
    input logic                          irq,
    input pmc_state_e                    st,
    input logic [MASK_W-1:0]             ovf_q,
    input logic [NUM_GEN-1:0][GEN_W-1:0] gen_val,
    input logic [CYC_W-1:0]              cyc_val
);
    localparam logic [MASK_W-1:0] MASK_VALID =
        (MASK_W'(1) << CYC_BIT) | ((MASK_W'(1) << NUM_GEN) - MASK_W'(1));

    // R3
    wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIPE) |=> (cyc_val == '0 && gen_val == '0));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IX_OV_CLR) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R6
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !wr_en) |=> ($stable(cyc_val) && $stable(gen_val)));

    // R7
    cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IX_CYC && st != ST_WIPE) |=> (cyc_val == $past(wr_data)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q == '0) |-> !irq);

    // R2
    ctl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_CTL) |-> (rd_data[2:1] == 2'b00 && rd_data[15:11] == 5'(NUM_GEN)));

    // R5
    mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_EN_SET || rd_idx == IX_OV_SET || rd_idx == IX_IE_SET)
            |-> ((rd_data[MASK_W-1:0] & ~MASK_VALID) == '0 && rd_data[CYC_W-1:MASK_W] == '0));

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_GEN_BASE || rd_idx == 12'h401) |-> (rd_data == '0));
endmodule

bind pmc_bank pmc_bank_chk #(
    .NUM_GEN (NUM_GEN),
    .GEN_W   (GEN_W),
    .CYC_W   (CYC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .irq     (irq),
    .st      (st),
    .ovf_q   (ovf_q),
    .gen_val (gen_val),
    .cyc_val (cyc_val)
);

// File: tb/pmc_bank_bench.sv
module pmc_bank_bench;
    localparam int NG = 8;
    localparam bit [31:0] VALID = 32'h8000_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_idx = 12'h000;
    logic [63:0] wr_data = 64'h0;
    logic [11:0] rd_idx = 12'h400;
    logic [63:0] rd_data;
    logic [NG-1:0] evt = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pmc_bank u_pmc_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .evt(evt), .irq(irq)
    );

    // behavioural reference model
    bit [31:0] m_en, m_ie, m_ov;
    bit [31:0] m_ctr [NG];
    bit [63:0] m_cyc;
    int        m_st;   // 0 off, 1 on, 2 wipe
    bit        m_res;

    always @(posedge clk) begin
        bit [31:0] hw;
        bit on, wp;
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_ov = 0; m_cyc = 0; m_st = 0; m_res = 0;
            for (int i = 0; i < NG; i++) m_ctr[i] = 0;
        end else begin
            hw = 0;
            on = (m_st == 1);
            wp = (m_st == 2);
            for (int i = 0; i < NG; i++) begin
                if (wp) m_ctr[i] = 0;
                else if (wr_en && wr_idx == 12'h421 + 12'(16 * i)) m_ctr[i] = wr_data[31:0];
                else if (on && m_en[i] && evt[i]) begin
                    if (m_ctr[i] == 32'hFFFF_FFFF) hw[i] = 1'b1;
                    m_ctr[i] = m_ctr[i] + 1;
                end
            end
            if (wp) m_cyc = 0;
            else if (wr_en && wr_idx == 12'h40A) m_cyc = wr_data;
            else if (on && m_en[31]) begin
                if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) hw[31] = 1'b1;
                m_cyc = m_cyc + 1;
            end
            if (wr_en) begin
                case (wr_idx)
                    12'h403: m_en = m_en & ~wr_data[31:0];
                    12'h404: m_en = m_en | wr_data[31:0];
                    12'h405: m_ie = m_ie & ~wr_data[31:0];
                    12'h406: m_ie = m_ie | wr_data[31:0];
                    12'h407: m_ov = m_ov & ~wr_data[31:0];
                    12'h408: m_ov = m_ov | wr_data[31:0];
                    default: ;
                endcase
            end
            m_en = m_en & VALID;
            m_ie = m_ie & VALID;
            m_ov = (m_ov | hw) & VALID;
            if (wr_en && wr_idx == 12'h400) begin
                if (wr_data[2:1] != 2'b00) begin m_st = 2; m_res = wr_data[0]; end
                else m_st = wr_data[0] ? 1 : 0;
            end else if (m_st == 2) m_st = m_res ? 1 : 0;
        end
    end

    function automatic bit [63:0] exp_rd(input logic [11:0] ix);
        bit [63:0] r = 0;
        case (ix)
            12'h400: begin r[15:11] = 5'(NG); r[0] = (m_st == 1) || (m_st == 2 && m_res); end
            12'h403, 12'h404: r[31:0] = m_en;
            12'h405, 12'h406: r[31:0] = m_ie;
            12'h407, 12'h408: r[31:0] = m_ov;
            12'h40A: r = m_cyc;
            default: ;
        endcase
        for (int i = 0; i < NG; i++)
            if (ix == 12'h421 + 12'(16 * i)) r[31:0] = m_ctr[i];
        return r;
    endfunction

    function automatic string tag_of(input logic [11:0] ix);
        if (ix == 12'h400) return "R2";
        if (ix >= 12'h403 && ix <= 12'h408) return "R4";
        if (ix == 12'h40A) return "R7";
        for (int i = 0; i < NG; i++)
            if (ix == 12'h421 + 12'(16 * i)) return "R6";
        return "R10";
    endfunction

    // every-clock comparison with the model
    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (rd_data !== exp_rd(rd_idx)) begin
                bad++;
                $display("FAIL %s model: idx %h actual %h expected %h",
                         tag_of(rd_idx), rd_idx, rd_data, exp_rd(rd_idx));
            end
            total++;
            if (irq !== ((m_ov & m_ie) != 0)) begin
                bad++;
                $display("FAIL R9 model irq: actual %b expected %b", irq, (m_ov & m_ie) != 0);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [11:0] ix, input logic [63:0] d);
        wr_en = 1'b1; wr_idx = ix; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [11:0] ix, input logic [63:0] exp, input string tag);
        rd_idx = ix;
        @(negedge clk);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: idx %h actual %h expected %h", tag, ix, rd_data, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic peek_irq(input logic exp, input string tag);
        @(negedge clk);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic sweep();
        rd_idx = 12'h400; idle(1);
        for (int k = 3; k <= 10; k++) begin rd_idx = 12'h400 + 12'(k); idle(1); end
        for (int i = 0; i < NG; i++) begin rd_idx = 12'h421 + 12'(16 * i); idle(1); end
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        started = 1'b1;

        // R1 reset state
        peek(12'h400, 64'h4000, "R1 ctl");
        peek(12'h404, 64'h0, "R1 enable");
        peek(12'h40A, 64'h0, "R1 cycle");
        peek(12'h421, 64'h0, "R1 ctr0");
        peek_irq(1'b0, "R1 irq");

        // R5 / R4 masks
        wr(12'h404, 64'hFFFF_FFFF_FFFF_FFFF);
        peek(12'h403, 64'h8000_00FF, "R5 valid bits");
        wr(12'h403, 64'h0000_00F0);
        peek(12'h404, 64'h8000_000F, "R4 clear");

        // R6 global off holds
        evt = '1; idle(3); evt = '0;
        peek(12'h421, 64'h0, "R6 global off");
        peek(12'h40A, 64'h0, "R6 global off cycle");

        // R6 counting
        wr(12'h400, 64'h1);
        peek(12'h400, 64'h4001, "R2 enable readback");
        evt = 8'b0000_0101; idle(4); evt = '0;
        peek(12'h421, 64'h4, "R6 ctr0");
        peek(12'h441, 64'h4, "R6 ctr2");
        peek(12'h431, 64'h0, "R6 ctr1 idle");
        evt = 8'hF0; idle(2); evt = '0;
        peek(12'h461, 64'h0, "R6 disabled ctr4");
        sweep();

        // R8 wrap, R9 interrupt
        wr(12'h431, 64'hFFFF_FFFF);
        wr(12'h406, 64'h2);
        evt = 8'h02; idle(1); evt = '0;
        peek(12'h431, 64'h0, "R8 wrap value");
        peek(12'h408, 64'h2, "R8 overflow flag");
        peek_irq(1'b1, "R9 raised");
        idle(3);
        peek_irq(1'b1, "R9 level held");

        // R8 wrap beats clear
        wr(12'h431, 64'hFFFF_FFFF);
        evt = 8'h02; wr(12'h407, 64'h2); evt = '0;
        peek(12'h408, 64'h2, "R8 set wins over clear");
        wr(12'h407, 64'h2);
        peek(12'h407, 64'h0, "R4 overflow clear");
        peek_irq(1'b0, "R9 dropped");

        // R7 write beats increment
        evt = 8'h01; wr(12'h421, 64'h1234); evt = '0;
        peek(12'h421, 64'h1234, "R7 write wins");

        // cycle counter wrap into bit 31
        wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFE);
        idle(2);
        peek(12'h408, 64'h8000_0000, "R8 cycle bit31");
        peek_irq(1'b0, "R9 not enabled");
        wr(12'h406, 64'h8000_0000);
        peek_irq(1'b1, "R9 cycle enabled");
        sweep();

        // R3 wipe
        wr(12'h400, 64'h7);
        peek(12'h400, 64'h4001, "R3 ctl during wipe");
        peek(12'h421, 64'h0, "R3 ctr0 wiped");
        peek(12'h40A, 64'h1, "R3 cycle restarted");
        peek(12'h408, 64'h8000_0000, "R3 overflow kept");
        wr(12'h400, 64'h2);
        idle(2);
        peek(12'h40A, 64'h0, "R3 wipe then off");
        peek(12'h400, 64'h4000, "R3 off after wipe");

        // R10 unmapped
        wr(12'h420, 64'hFFFF);
        wr(12'h402, 64'hFFFF);
        peek(12'h420, 64'h0, "R10 counter control");
        peek(12'h401, 64'h0, "R10 gap");
        peek(12'h4FF, 64'h0, "R10 far");
        peek(12'h404, 64'h8000_000F, "R10 enable untouched");

        // R5 overflow set with invalid bits
        wr(12'h408, 64'hFFFF_FFFF);
        peek(12'h408, 64'h8000_00FF, "R5 overflow valid bits");
        wr(12'h405, 64'hFFFF_FFFF);
        peek_irq(1'b0, "R9 all interrupts off");
        wr(12'h407, 64'hFFFF_FFFF);
        sweep();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule